// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block holds the pending-request vector of one interrupt controller. Each of its request lines can be captured in one of two ways, chosen per line by a trigger-select register. A line in level mode tracks its input. A line in edge mode latches a rising edge and keeps it until the request is acknowledged or the controller is re-initialised.

The trigger-select register is written through a simple strobe-and-data port. The written value is ANDed with a write mask that is fixed for each instance, so some lines can be made permanently edge-sensitive. An acknowledge strobe carries a line index and retires an edge request on that line. A controller-reset strobe drops edge requests and the edge history, but keeps level requests. A registered one-cycle flag per line reports each request that has just become pending.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst_n` is low, `pend`, `trig_sel` and `new_set` are all zero.
- R2: A write with `trig_wr` high loads `trig_wdata & WR_MASK` into `trig_sel` at the next clock edge. A 1 selects level mode for that line and a 0 selects edge mode. With the default mask 8'hF8, lines 0 to 2 always stay in edge mode.
- R3: In a cycle without `ctl_reset`, a level-mode line's pending bit becomes its input value at the next edge.
- R4: In edge mode, an input that is high after being low in the previous cycle sets the pending bit. A later low input leaves the pending bit set.
- R5: In edge mode, an input that stays high raises no new request. After an acknowledge, the bit stays clear until the input goes low and then high again.
- R6: `ack_en` with index `ack_idx` clears that line's pending bit if the line is in edge mode. A level-mode line keeps its pending bit.
- R7: When an acknowledge and a new rising edge hit the same edge-mode line in the same cycle, the line ends up pending.
- R8: `ctl_reset` sets `pend` to its old value ANDed with `trig_sel`, ignores the inputs in that cycle, and clears the edge history. An input still high afterwards is therefore taken as a new edge in the next cycle. `trig_sel` is unchanged by it.
- R9: `new_set[i]` is high for exactly one cycle after the edge at which `pend[i]` went from 0 to 1. It stays low if that line was already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | NUM_LINES | Request input lines |
| trig_wr | input | 1 | Trigger-select write strobe |
| trig_wdata | input | NUM_LINES | Trigger-select write data |
| ack_en | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Line retired by the acknowledge |
| ctl_reset | input | 1 | Controller re-initialisation strobe |
| pend | output | NUM_LINES | Pending-request vector |
| trig_sel | output | NUM_LINES | Trigger-select vector, 1 = level |
| new_set | output | NUM_LINES | Newly pending flag per line |

## Verification
The hardest state to reach from the ports is the edge history. It cannot be seen directly, yet it decides whether a held-high input raises a request after an acknowledge or after a controller reset. The stimulus holds an edge line high across an acknowledge to show that nothing is re-latched. It then issues a controller reset with the same input still high and checks that the request comes back on the following cycle. This shows that the history was cleared.

// File: rtl/irq_req_latch_pkg.sv
package irq_req_latch_pkg;

  typedef struct packed {
    logic pend;
    logic last;
    logic fresh;
  } line_state_t;

  // Apply the per-instance write mask to a trigger-select write.
  function automatic logic [7:0] mask_write(input logic [7:0] data, input logic [7:0] msk);
    return data & msk;
  endfunction

  // Next state of one request line for one clock edge.
  function automatic line_state_t line_next(
    input logic req,
    input logic level_mode,
    input logic ack_hit,
    input logic ctl_rst,
    input logic pend_q,
    input logic last_q
  );
    line_state_t n;
    logic rise;
    n.pend  = pend_q;
    n.last  = last_q;
    n.fresh = 1'b0;
    if (ctl_rst) begin
      n.last = 1'b0;
      n.pend = pend_q & level_mode;
    end else if (level_mode) begin
      n.pend = req;
      n.last = req;
    end else begin
      rise = req & ~last_q;
      if (rise) n.pend = 1'b1;
      else if (ack_hit) n.pend = 1'b0;
      n.last = req;
    end
    n.fresh = n.pend & ~pend_q;
    return n;
  endfunction

endpackage

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
  parameter int NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] sel
);
  logic [NUM_LINES-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (wr) sel_q <= wdata & WR_MASK;
  end

  assign sel = sel_q;
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_req_latch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic level_mode,
  input  logic ack_hit,
  input  logic ctl_rst,
  output logic pend,
  output logic fresh,
  output logic rise_evt
);
  logic        pend_q, last_q, fresh_q;
  line_state_t nxt;

  always_comb nxt = line_next(req, level_mode, ack_hit, ctl_rst, pend_q, last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      last_q  <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      pend_q  <= nxt.pend;
      last_q  <= nxt.last;
      fresh_q <= nxt.fresh;
    end
  end

  assign pend     = pend_q;
  assign fresh    = fresh_q;
  assign rise_evt = ~ctl_rst & ~level_mode & req & ~last_q;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK = 8'hF8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_in,
  input  logic                 trig_wr,
  input  logic [NUM_LINES-1:0] trig_wdata,
  input  logic                 ack_en,
  input  logic [IDX_W-1:0]     ack_idx,
  input  logic                 ctl_reset,
  output logic [NUM_LINES-1:0] pend,
  output logic [NUM_LINES-1:0] trig_sel,
  output logic [NUM_LINES-1:0] new_set
);
  logic [NUM_LINES-1:0] ack_hit;
  logic [NUM_LINES-1:0] rise_evt;

  irq_trig_reg #(.NUM_LINES(NUM_LINES), .WR_MASK(WR_MASK)) u_trig (
    .clk(clk), .rst_n(rst_n), .wr(trig_wr), .wdata(trig_wdata), .sel(trig_sel)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign ack_hit[i] = ack_en && (ack_idx == IDX_W'(i));
    irq_line_cell u_cell (
      .clk(clk), .rst_n(rst_n), .req(req_in[i]), .level_mode(trig_sel[i]),
      .ack_hit(ack_hit[i]), .ctl_rst(ctl_reset),
      .pend(pend[i]), .fresh(new_set[i]), .rise_evt(rise_evt[i])
    );
  end
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
  parameter int NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK = 8'hF8,
  parameter int IDX_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] req_in,
  input logic                 ack_en,
  input logic [IDX_W-1:0]     ack_idx,
  input logic                 ctl_reset,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] trig_sel,
  input logic [NUM_LINES-1:0] new_set,
  input logic [NUM_LINES-1:0] rise_evt
);
  always_comb if (rst_n) AST_TRIG_MASKED: assert ((trig_sel & ~WR_MASK) == '0); // R2

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_reset |=> ((pend & $past(trig_sel)) == ($past(req_in) & $past(trig_sel)))); // R3

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_reset && !ack_en) |=> (($past(pend) & ~$past(trig_sel) & ~pend) == '0)); // R4

  AST_ACK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !ctl_reset && !trig_sel[ack_idx] && !rise_evt[ack_idx]) |=> !pend[$past(ack_idx)]); // R6

  AST_ACK_RISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && rise_evt[ack_idx]) |=> pend[$past(ack_idx)]); // R7

  AST_CTL_RESET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> (pend == ($past(pend) & $past(trig_sel)))); // R8

  AST_NEW_IS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (new_set == (pend & ~$past(pend)))); // R9
endmodule

bind irq_req_latch irq_req_latch_chk #(.NUM_LINES(NUM_LINES), .WR_MASK(WR_MASK), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_en(ack_en), .ack_idx(ack_idx),
  .ctl_reset(ctl_reset), .pend(pend), .trig_sel(trig_sel), .new_set(new_set), .rise_evt(rise_evt)
);

// File: tb/irq_req_latch_bench.sv
module irq_req_latch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0;
  logic       trig_wr = 1'b0;
  logic [7:0] trig_wdata = '0;
  logic       ack_en = 1'b0;
  logic [2:0] ack_idx = '0;
  logic       ctl_reset = 1'b0;
  logic [7:0] pend, trig_sel, new_set;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_req_latch u_irq_req_latch (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_wr(trig_wr), .trig_wdata(trig_wdata),
    .ack_en(ack_en), .ack_idx(ack_idx), .ctl_reset(ctl_reset),
    .pend(pend), .trig_sel(trig_sel), .new_set(new_set)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs after a falling edge, then wait for the next falling edge.
  task automatic cyc(input logic [7:0] r, input logic ae, input logic [2:0] ai,
                     input logic cr, input logic wr, input logic [7:0] wd);
    req_in = r; ack_en = ae; ack_idx = ai; ctl_reset = cr; trig_wr = wr; trig_wdata = wd;
    @(negedge clk);
    ack_en = 0; ctl_reset = 0; trig_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 pend", pend, 8'h00);
    chk("R1 trig_sel", trig_sel, 8'h00);
    chk("R1 new_set", new_set, 8'h00);
  endtask

  task automatic t_trig_write();
    cyc(8'h00, 0, 0, 0, 1, 8'hFF);
    chk("R2 masked write", trig_sel, 8'hF8);
  endtask

  task automatic t_edge();
    cyc(8'h01, 0, 0, 0, 0, 0);
    chk("R4 rise sets", pend, 8'h01);
    chk("R9 new pulse", new_set, 8'h01);
    cyc(8'h00, 0, 0, 0, 0, 0);
    chk("R4 held after low", pend, 8'h01);
    chk("R9 pulse one cycle", new_set, 8'h00);
    cyc(8'h01, 0, 0, 0, 0, 0);
    chk("R9 no pulse when already pending", new_set, 8'h00);
  endtask

  task automatic t_ack();
    cyc(8'h01, 1, 0, 0, 0, 0);
    chk("R6 ack clears edge", pend, 8'h00);
    cyc(8'h01, 0, 0, 0, 0, 0);
    chk("R5 held high no reset", pend, 8'h00);
  endtask

  task automatic t_collision();
    cyc(8'h00, 0, 0, 0, 0, 0);
    cyc(8'h01, 1, 0, 0, 0, 0);
    chk("R7 edge beats ack", pend, 8'h01);
  endtask

  task automatic t_level();
    cyc(8'h11, 0, 0, 0, 0, 0);
    chk("R3 level follows high", pend, 8'h11);
    chk("R9 level pulse", new_set, 8'h10);
    cyc(8'h11, 1, 4, 0, 0, 0);
    chk("R6 level ignores ack", pend, 8'h11);
    cyc(8'h01, 0, 0, 0, 0, 0);
    chk("R3 level follows low", pend, 8'h01);
    cyc(8'h11, 0, 0, 0, 0, 0);
    chk("R3 level re-high", pend, 8'h11);
  endtask

  task automatic t_ctl_reset();
    cyc(8'h11, 0, 0, 1, 0, 0);
    chk("R8 keep level only", pend, 8'h10);
    chk("R8 trig_sel kept", trig_sel, 8'hF8);
    chk("R9 no pulse on ctl reset", new_set, 8'h00);
    cyc(8'h11, 0, 0, 0, 0, 0);
    chk("R8 history cleared", pend, 8'h11);
    chk("R8 new edge pulse", new_set, 8'h01);
  endtask

  initial begin
    #5;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_trig_write();
    t_edge();
    t_ack();
    t_collision();
    t_level();
    t_ctl_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule